// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It walks a two-level translation table held in memory. A requester presents the virtual address and an access kind (read, write or instruction fetch). A root-pointer input gives the physical base of the top-level directory of the current address space, so loading a new value there moves every later walk into another address space. The walker fetches one directory entry and then, if that entry is present, one leaf entry. It uses a memory read port with a valid/ready request handshake and a response-valid strobe, and it never has more than one read outstanding.

Every table entry is one 32-bit word. Bit 0 is the present flag, bit 1 allows reads, bit 2 allows writes and bit 3 allows fetches. Bit 4 is a dirty flag and bits [11:5] are spare. Bits [31:12] hold a 20-bit frame number. In a directory entry that frame number locates the leaf table. In a leaf entry it forms the upper part of the physical address, and the 12-bit page offset is appended unchanged. A walk ends with a one-cycle `done` pulse that carries either the physical address or a 2-bit fault code.

The controller has six named states: IDLE, READ_PDE, WAIT_PDE, READ_PTE, WAIT_PTE and DONE. The transitions are:
- IDLE to READ_PDE when a request is presented.
- READ_PDE to WAIT_PDE when the directory read is accepted.
- WAIT_PDE to READ_PTE on a response with the present flag set.
- WAIT_PDE to DONE on a response with the present flag clear.
- READ_PTE to WAIT_PTE when the leaf read is accepted.
- WAIT_PTE to DONE on a response.
- DONE to IDLE unconditionally.

Top module: `ptw_walker`

## Requirements
- R1: After a synchronous active-high reset, `req_ready` is 1, and `mem_req_valid`, `done`, `fault` and `paddr` are all 0.
- R2: A request is taken only when `req_valid` and `req_ready` are both high. `req_ready` stays low from that edge until `done` has been shown, so a request held during a walk does not start a second walk.
- R3: The first read goes to `root + vaddr[31:22]*4`, using the root pointer captured when the request was taken. Changes on `root_base` during a walk have no effect on that walk.
- R4: The second read goes to `{dir_entry[31:12], 12'h000} + vaddr[21:12]*4`.
- R5: While `mem_req_valid` is high and `mem_req_ready` is low, `mem_req_valid` stays high and `mem_req_addr` stays unchanged on the next cycle.
- R6: A directory entry with bit 0 clear ends the walk with fault code 1 and `paddr` 0, and no second read is issued.
- R7: A leaf entry with bit 0 clear ends the walk with fault code 2 and `paddr` 0.
- R8: Access code 0 (read) needs leaf bit 1, code 1 (write) needs leaf bit 2, and code 2 (fetch) needs leaf bit 3. Code 3 is never permitted. A walk that is not permitted ends with fault code 3 and `paddr` 0.
- R9: A permitted walk ends with fault code 0 and `paddr = {leaf[31:12], vaddr[11:0]}`.
- R10: `done` is high for exactly one cycle per walk. `fault` and `paddr` read 0 whenever `done` is low. The walker is ready again on the cycle after `done`.
- R11: The walker does not issue a new read request before the response to the previous one has arrived.
- R12: Leaf bits [11:4] and directory bits [11:1] have no effect on the outcome. Only the directory's present flag and frame number matter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 not permitted |
| root_base | input | 32 | Physical base of the current top-level directory |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 32 | Physical address of the entry to read |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Entry word returned by memory |
| done | output | 1 | One-cycle result strobe |
| fault | output | 2 | 0 none, 1 directory absent, 2 leaf absent, 3 access denied |
| paddr | output | 32 | Translated physical address, 0 on a fault |

## Verification
Two events can land in the same cycle. One is a directory response with the present flag clear. The other is a leaf entry that is present but denies the access kind. The first must win, so the walk ends with code 1 and only one read is made. The bench provokes this by mapping a denying leaf under a directory word whose present flag is clear. It then judges the result by the fault code and by the count of reads seen on the memory port. A second clash is a new request held high during a walk while `root_base` is being changed. The bench judges this by the directory address it observes and by the number of reads.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [2:0] {
        IDLE     = 3'd0,
        READ_PDE = 3'd1,
        WAIT_PDE = 3'd2,
        READ_PTE = 3'd3,
        WAIT_PTE = 3'd4,
        DONE     = 3'd5
    } walk_state_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_NONE  = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_DIR  = 2'd1,
        FLT_LEAF = 2'd2,
        FLT_PERM = 2'd3
    } fault_e;

    localparam int unsigned FLAG_PRESENT = 0;
    localparam int unsigned FLAG_READ    = 1;
    localparam int unsigned FLAG_WRITE   = 2;
    localparam int unsigned FLAG_FETCH   = 3;

endpackage

// File: rtl/ptw_entry_decode.sv
module ptw_entry_decode #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned OFF_W  = 12,
    localparam int unsigned FRAME_W = ADDR_W - OFF_W
) (
    input  logic [ADDR_W-1:0]  entry,
    output logic               present,
    output logic               can_read,
    output logic               can_write,
    output logic               can_fetch,
    output logic [FRAME_W-1:0] frame
);
    import ptw_pkg::*;

    always_comb begin
        present   = entry[FLAG_PRESENT];
        can_read  = entry[FLAG_READ];
        can_write = entry[FLAG_WRITE];
        can_fetch = entry[FLAG_FETCH];
        frame     = entry[ADDR_W-1:OFF_W];
    end
endmodule

// File: rtl/ptw_perm_check.sv
module ptw_perm_check (
    input  ptw_pkg::acc_kind_e acc,
    input  logic               can_read,
    input  logic               can_write,
    input  logic               can_fetch,
    output logic               allowed
);
    import ptw_pkg::*;

    always_comb begin
        unique case (acc)
            ACC_READ:  allowed = can_read;
            ACC_WRITE: allowed = can_write;
            ACC_FETCH: allowed = can_fetch;
            ACC_NONE:  allowed = 1'b0;
            default:   allowed = 1'b0;
        endcase
    end
endmodule

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr #(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned IDX_W   = 10,
    parameter int unsigned ENT_LOG = 2
) (
    input  logic [ADDR_W-1:0] table_base,
    input  logic [IDX_W-1:0]  index,
    output logic [ADDR_W-1:0] entry_addr
);
    localparam int unsigned SCALED_W = IDX_W + ENT_LOG;

    logic [SCALED_W-1:0] scaled;

    always_comb begin
        scaled     = {index, {ENT_LOG{1'b0}}};
        entry_addr = table_base + ADDR_W'(scaled);
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker #(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned OFF_W   = 12,
    parameter int unsigned LEAF_W  = 10,
    parameter int unsigned ENT_LOG = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic [1:0]        req_acc,
    input  logic [ADDR_W-1:0] root_base,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [ADDR_W-1:0] mem_rsp_data,
    output logic              done,
    output logic [1:0]        fault,
    output logic [ADDR_W-1:0] paddr
);
    import ptw_pkg::*;

    localparam int unsigned FRAME_W = ADDR_W - OFF_W;
    localparam int unsigned DIR_W   = ADDR_W - OFF_W - LEAF_W;
    localparam int unsigned IDX_W   = (DIR_W > LEAF_W) ? DIR_W : LEAF_W;

    walk_state_e         state_q, state_d;
    logic [ADDR_W-1:0]   vaddr_q;
    acc_kind_e           acc_q;
    logic [ADDR_W-1:0]   root_q;
    logic [FRAME_W-1:0]  leaf_tbl_q;
    fault_e              fault_q;
    logic [ADDR_W-1:0]   paddr_q;

    logic                ent_present, ent_rd, ent_wr, ent_fx;
    logic [FRAME_W-1:0]  ent_frame;
    logic                access_ok;
    logic                leaf_phase;
    logic [ADDR_W-1:0]   walk_base;
    logic [IDX_W-1:0]    walk_idx;
    logic [DIR_W-1:0]    dir_idx;
    logic [LEAF_W-1:0]   leaf_idx;

    ptw_entry_decode #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W)
    ) u_decode (
        .entry     (mem_rsp_data),
        .present   (ent_present),
        .can_read  (ent_rd),
        .can_write (ent_wr),
        .can_fetch (ent_fx),
        .frame     (ent_frame)
    );

    ptw_perm_check u_perm (
        .acc       (acc_q),
        .can_read  (ent_rd),
        .can_write (ent_wr),
        .can_fetch (ent_fx),
        .allowed   (access_ok)
    );

    always_comb begin
        dir_idx    = vaddr_q[ADDR_W-1:OFF_W+LEAF_W];
        leaf_idx   = vaddr_q[OFF_W+LEAF_W-1:OFF_W];
        leaf_phase = (state_q == READ_PTE) || (state_q == WAIT_PTE);
        walk_base  = leaf_phase ? {leaf_tbl_q, {OFF_W{1'b0}}} : root_q;
        walk_idx   = leaf_phase ? IDX_W'(leaf_idx) : IDX_W'(dir_idx);
    end

    ptw_entry_addr #(
        .ADDR_W  (ADDR_W),
        .IDX_W   (IDX_W),
        .ENT_LOG (ENT_LOG)
    ) u_addr (
        .table_base (walk_base),
        .index      (walk_idx),
        .entry_addr (mem_req_addr)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= IDLE;
        else     state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IDLE:     if (req_valid)     state_d = READ_PDE;
            READ_PDE: if (mem_req_ready) state_d = WAIT_PDE;
            WAIT_PDE: if (mem_rsp_valid) state_d = ent_present ? READ_PTE : DONE;
            READ_PTE: if (mem_req_ready) state_d = WAIT_PTE;
            WAIT_PTE: if (mem_rsp_valid) state_d = DONE;
            DONE:                        state_d = IDLE;
            default:                     state_d = IDLE;
        endcase
    end

    // Walk data and result registers
    always_ff @(posedge clk) begin
        if (rst) begin
            vaddr_q    <= '0;
            acc_q      <= ACC_READ;
            root_q     <= '0;
            leaf_tbl_q <= '0;
            fault_q    <= FLT_NONE;
            paddr_q    <= '0;
        end else begin
            unique case (state_q)
                IDLE: begin
                    if (req_valid) begin
                        vaddr_q <= req_vaddr;
                        acc_q   <= acc_kind_e'(req_acc);
                        root_q  <= root_base;
                        fault_q <= FLT_NONE;
                        paddr_q <= '0;
                    end
                end
                WAIT_PDE: begin
                    if (mem_rsp_valid) begin
                        if (!ent_present) fault_q    <= FLT_DIR;
                        else              leaf_tbl_q <= ent_frame;
                    end
                end
                WAIT_PTE: begin
                    if (mem_rsp_valid) begin
                        if (!ent_present)    fault_q <= FLT_LEAF;
                        else if (!access_ok) fault_q <= FLT_PERM;
                        else                 paddr_q <= {ent_frame, vaddr_q[OFF_W-1:0]};
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        req_ready     = (state_q == IDLE);
        mem_req_valid = (state_q == READ_PDE) || (state_q == READ_PTE);
        done          = (state_q == DONE);
        fault         = done ? fault_q : FLT_NONE;
        paddr         = done ? paddr_q : '0;
    end
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned OFF_W  = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_vaddr,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              mem_rsp_valid,
    input logic              done,
    input logic [1:0]        fault,
    input logic [ADDR_W-1:0] paddr
);
    logic [OFF_W-1:0] off_seen;
    logic             rd_open;

    always_ff @(posedge clk) begin
        if (rst) begin
            off_seen <= '0;
            rd_open  <= 1'b0;
        end else begin
            if (req_valid && req_ready) off_seen <= req_vaddr[OFF_W-1:0];
            if (mem_req_valid && mem_req_ready) rd_open <= 1'b1;
            else if (mem_rsp_valid)             rd_open <= 1'b0;
        end
    end

    // R5
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && req_ready));

    // R10
    quiet_result_chk: assert property (@(posedge clk) disable iff (rst)
        !done |-> (fault == 2'd0 && paddr == '0));

    // R6
    fault_no_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (done && fault != 2'd0) |-> (paddr == '0));

    // R2
    busy_after_take_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R9
    offset_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (done && fault == 2'd0) |-> (paddr[OFF_W-1:0] == off_seen));

    // R11
    single_read_chk: assert property (@(posedge clk) disable iff (rst)
        rd_open |-> !mem_req_valid);

    // R2
    idle_no_read_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !mem_req_valid);
endmodule

bind ptw_walker ptw_walker_chk #(
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_vaddr     (req_vaddr),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .done          (done),
    .fault         (fault),
    .paddr         (paddr)
);

// File: tb/tb_ptw_walker.sv
module tb_ptw_walker;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_acc = '0;
    logic [31:0] root_base = '0;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        done;
    logic [1:0]  fault;
    logic [31:0] paddr;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    ptw_walker dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_acc(req_acc), .root_base(root_base),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .done(done), .fault(fault), .paddr(paddr)
    );

    // Memory model
    logic [31:0] mem [logic [31:0]];
    int          stall = 0;
    int          lat = 0;
    int          wait_cnt = 0;
    int          cnt = 0;
    logic        pend = 1'b0;
    logic [31:0] pend_a = '0;
    logic [31:0] log_a [64];
    int          tot = 0;
    int          hold_err = 0;
    logic        was_stalled = 1'b0;
    logic [31:0] stalled_a = '0;

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    assign mem_req_ready = (wait_cnt >= stall);

    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        if (mem_req_valid && !mem_req_ready) wait_cnt <= wait_cnt + 1;
        else                                 wait_cnt <= 0;
        if (mem_req_valid && mem_req_ready) begin
            pend   <= 1'b1;
            cnt    <= lat;
            pend_a <= mem_req_addr;
            log_a[tot % 64] <= mem_req_addr;
            tot    <= tot + 1;
        end else if (pend) begin
            if (cnt == 0) begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_data  <= rd(pend_a);
                pend          <= 1'b0;
            end else begin
                cnt <= cnt - 1;
            end
        end
    end

    always @(negedge clk) begin
        if (mem_req_valid && !mem_req_ready) begin
            if (was_stalled && mem_req_addr != stalled_a) hold_err <= hold_err + 1;
            was_stalled <= 1'b1;
            stalled_a   <= mem_req_addr;
        end else begin
            was_stalled <= 1'b0;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] dir_addr(input logic [31:0] root, input logic [31:0] va);
        return root + {20'h0, va[31:22], 2'b00};
    endfunction

    function automatic logic [31:0] leaf_addr(input logic [31:0] de, input logic [31:0] va);
        return {de[31:12], 12'h000} + {20'h0, va[21:12], 2'b00};
    endfunction

    task automatic map(input logic [31:0] root, input logic [31:0] va,
                       input logic [31:0] de, input logic [31:0] le);
        mem[dir_addr(root, va)] = de;
        if (de[0]) mem[leaf_addr(de, va)] = le;
    endtask

    logic [1:0]  r_fault;
    logic [31:0] r_paddr;
    int          r_reads;
    int          r_first;

    task automatic walk(input logic [31:0] va, input logic [1:0] acc, input bit hold_req,
                        input logic [31:0] new_root, input bit swap_root);
        int  cyc = 0;
        bit  busy_bad = 0;
        @(negedge clk);
        req_vaddr = va;
        req_acc   = acc;
        req_valid = 1'b1;
        r_first   = tot;
        @(posedge clk);
        @(negedge clk);
        if (swap_root) root_base = new_root;
        if (!hold_req) req_valid = 1'b0;
        else           req_vaddr = va ^ 32'h5555_0000;
        while (!done && cyc < 300) begin
            if (req_ready) busy_bad = 1;
            @(negedge clk);
            cyc++;
        end
        chk(cyc < 300, "R10 walk completes", cyc, 300);
        chk(!busy_bad, "R2 ready low during walk", busy_bad, 0);
        r_fault   = fault;
        r_paddr   = paddr;
        req_valid = 1'b0;
        r_reads   = tot - r_first;
        @(negedge clk);
        chk(!done, "R10 done one cycle", done, 0);
        chk(req_ready, "R10 ready after done", req_ready, 1);
        chk(fault == 2'd0 && paddr == 32'h0, "R10 result quiet", {fault, paddr[29:0]}, 0);
        r_reads = tot - r_first;
    endtask

    task automatic t_reset();
        chk(req_ready == 1'b1, "R1 req_ready", req_ready, 1);
        chk(mem_req_valid == 1'b0, "R1 mem_req_valid", mem_req_valid, 0);
        chk(done == 1'b0 && fault == 2'd0 && paddr == 32'h0, "R1 outputs", paddr, 0);
    endtask

    task automatic t_read_ok();
        logic [31:0] root = 32'h0010_0000, va = 32'h4123_B538;
        logic [31:0] de = 32'h0002_0001, le = 32'hC20A_3003;
        map(root, va, de, le);
        root_base = root;
        walk(va, 2'd0, 0, 0, 0);
        chk(r_fault == 2'd0, "R9 fault", r_fault, 0);
        chk(r_paddr == {le[31:12], va[11:0]}, "R9 paddr", r_paddr, {le[31:12], va[11:0]});
        chk(r_reads == 2, "R11 read count", r_reads, 2);
        chk(log_a[r_first % 64] == dir_addr(root, va), "R3 dir addr", log_a[r_first % 64], dir_addr(root, va));
        chk(log_a[(r_first + 1) % 64] == leaf_addr(de, va), "R4 leaf addr",
            log_a[(r_first + 1) % 64], leaf_addr(de, va));
    endtask

    task automatic t_perm();
        logic [31:0] root = 32'h0030_0000, va = 32'h1004_5ABC;
        logic [31:0] de = 32'h0004_0001;
        map(root, va, de, 32'h1234_5003);
        root_base = root;
        walk(va, 2'd1, 0, 0, 0);
        chk(r_fault == 2'd3, "R8 write to read-only", r_fault, 3);
        chk(r_paddr == 32'h0, "R8 paddr zero", r_paddr, 0);
        walk(va, 2'd2, 0, 0, 0);
        chk(r_fault == 2'd3, "R8 fetch non-exec", r_fault, 3);
        mem[leaf_addr(de, va)] = 32'h1234_5009;
        walk(va, 2'd2, 0, 0, 0);
        chk(r_fault == 2'd0 && r_paddr == {20'h12345, va[11:0]}, "R8 fetch exec ok", r_paddr, {20'h12345, va[11:0]});
        walk(va, 2'd0, 0, 0, 0);
        chk(r_fault == 2'd3, "R8 read denied when only exec", r_fault, 3);
        mem[leaf_addr(de, va)] = 32'h1234_500F;
        walk(va, 2'd3, 0, 0, 0);
        chk(r_fault == 2'd3, "R8 code 3 denied", r_fault, 3);
    endtask

    task automatic t_missing();
        logic [31:0] root = 32'h0050_0000, va = 32'h8000_1000;
        // directory absent while the leaf it would point to denies the access
        map(root, va, 32'h0006_000E, 32'h0);
        mem[leaf_addr(32'h0006_0000, va)] = 32'h7777_7001;
        root_base = root;
        walk(va, 2'd1, 0, 0, 0);
        chk(r_fault == 2'd1, "R6 dir fault", r_fault, 1);
        chk(r_paddr == 32'h0, "R6 paddr zero", r_paddr, 0);
        chk(r_reads == 1, "R6 single read", r_reads, 1);
        map(root, va, 32'h0006_0001, 32'h7777_700E);
        walk(va, 2'd0, 0, 0, 0);
        chk(r_fault == 2'd2, "R7 leaf fault", r_fault, 2);
        chk(r_paddr == 32'h0, "R7 paddr zero", r_paddr, 0);
        chk(r_reads == 2, "R7 read count", r_reads, 2);
    endtask

    task automatic t_stall();
        logic [31:0] root = 32'h0070_0000, va = 32'hFFFF_F123;
        logic [31:0] de = 32'h0008_0001, le = 32'hABCD_E005;
        int he;
        map(root, va, de, le);
        root_base = root;
        stall = 3; lat = 4;
        he = hold_err;
        walk(va, 2'd1, 0, 0, 0);
        chk(hold_err == he, "R5 addr stable under stall", hold_err, he);
        chk(r_fault == 2'd0 && r_paddr == {le[31:12], va[11:0]}, "R9 paddr after stall",
            r_paddr, {le[31:12], va[11:0]});
        chk(log_a[(r_first + 1) % 64] == leaf_addr(de, va), "R4 leaf addr under stall",
            log_a[(r_first + 1) % 64], leaf_addr(de, va));
        stall = 0; lat = 0;
    endtask

    task automatic t_switch();
        logic [31:0] ra = 32'h0090_0000, rb = 32'h00A0_0000, va = 32'h0040_0010;
        map(ra, va, 32'h000B_0001, 32'h1111_1003);
        map(rb, va, 32'h000C_0001, 32'h2222_2003);
        root_base = ra;
        walk(va, 2'd0, 1, rb, 1);
        chk(log_a[r_first % 64] == dir_addr(ra, va), "R3 root captured at take",
            log_a[r_first % 64], dir_addr(ra, va));
        chk(r_paddr == {20'h11111, va[11:0]}, "R3 old space result", r_paddr, {20'h11111, va[11:0]});
        chk(r_reads == 2, "R2 held request ignored", r_reads, 2);
        walk(va, 2'd0, 0, 0, 0);
        chk(r_paddr == {20'h22222, va[11:0]}, "R3 new space result", r_paddr, {20'h22222, va[11:0]});
    endtask

    task automatic t_spare_bits();
        logic [31:0] root = 32'h00D0_0000, va = 32'h7654_3210;
        map(root, va, 32'h000E_0FF1, 32'h3333_3FF5);
        root_base = root;
        walk(va, 2'd1, 0, 0, 0);
        chk(r_fault == 2'd0, "R12 spare bits no fault", r_fault, 0);
        chk(r_paddr == {20'h33333, va[11:0]}, "R12 spare bits paddr", r_paddr, {20'h33333, va[11:0]});
        chk(log_a[(r_first + 1) % 64] == leaf_addr(32'h000E_0000, va), "R12 dir flags ignored",
            log_a[(r_first + 1) % 64], leaf_addr(32'h000E_0000, va));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_read_ok();
        t_perm();
        t_missing();
        t_stall();
        t_switch();
        t_spare_bits();
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule